// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell

This block is one logic cell of a small programmable logic array. Static configuration inputs set its function. It builds five AND product terms over the concatenation of a global and a regional input bus. A steering stage passes each term to the OR sum, or takes three of them away for a private job: the second XOR operand, a separate flip-flop data input, or the output enable. A cascade input from the neighbouring cell is ORed into the sum, and the combined sum leaves through a cascade output, so up to eight cells in a chain can build a 40-term sum.

The sum passes through an XOR stage. Its second operand can be constant 0, constant 1 (which inverts the polarity), the steered term, or the cell's own register output (which makes a toggle register). The register takes either the XOR result or its own steered term. Two independent select bits then pick a combinational or registered value, one for the pin and one for the array feedback. An enable flag reports whether the pin drives.

Top module: `pld_macrocell`

## Requirements
- R1: Literal vector `lit = {rgn_i, glb_i}` (glb_i in the low bits). Term t is the AND of every literal k with `true_en_i[t*IN_W+k]` set and every complemented literal k with `comp_en_i[t*IN_W+k]` set. A term with no enabled literal is 1.
- R2: `route_i[0]` takes term 0 out of the sum for the XOR operand, `route_i[1]` takes term 1 for flip-flop data, `route_i[2]` takes term 2 for the output enable. A term that is not routed goes to the sum, and terms 3 and 4 always go to the sum.
- R3: The sum is the OR of the summed terms and `cascade_i`. `cascade_o` equals the sum combinationally.
- R4: Eight cells chained through cascade_o to cascade_i give a last-cell cascade_o that is the OR of all 40 terms.
- R5: `xor_mode_i` sets the XOR output: 0 gives sum, 1 gives ~sum, 2 gives sum ^ term0 (term0 is taken as 0 when `route_i[0]` is clear), 3 gives sum ^ Q, so Q toggles on each rising edge while the sum is 1.
- R6: With `d_sel_i` = 0 the register loads the XOR output on each rising edge. With `d_sel_i` = 1 it loads term 1, taken as 0 when `route_i[1]` is clear.
- R7: `pin_o` is the XOR output when `out_sel_i` = 0 and Q when it is 1. `fb_o` makes the same choice from `fb_sel_i`, independently of `out_sel_i`.
- R8: `oe_mode_i` sets `pin_oe_o`: 0 gives 0, 1 gives 1, 2 gives term 2 (0 when `route_i[2]` is clear), 3 gives 0. The enable does not change the value of `pin_o`.
- R9: `rst_ni` low clears Q asynchronously. `clr_i` high at a rising edge loads 0 and takes precedence over the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous register clear |
| glb_i | input | GLB_W | Global bus literals |
| rgn_i | input | RGN_W | Regional bus literals |
| cascade_i | input | 1 | Sum from the neighbouring cell |
| true_en_i | input | 5*IN_W | True-literal enables per term |
| comp_en_i | input | 5*IN_W | Complement-literal enables per term |
| route_i | input | 3 | Steering of terms 0..2 to their private use |
| xor_mode_i | input | 2 | Second XOR operand select |
| d_sel_i | input | 1 | Register data source |
| out_sel_i | input | 1 | Pin combinational/registered select |
| fb_sel_i | input | 1 | Feedback combinational/registered select |
| oe_mode_i | input | 2 | Output enable mode |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin enable, low means high-impedance |
| fb_o | output | 1 | Feedback to the array |
| cascade_o | output | 1 | Sum passed to the next cell |

## Verification
The bench builds the cell with GLB_W = 4 and RGN_W = 4, so there are eight literals per term. Sparse random literal masks then make each term true often enough that every steering choice, XOR mode and output select sees both values. The bench also wires eight of these cells into a chain and moves a single true term through all 40 positions. This reaches the full cascade length and checks that each term lands in the right cell.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  localparam int N_PT    = 5;
  localparam int N_STEER = 3;
  localparam int PT_XOR  = 0;
  localparam int PT_FFD  = 1;
  localparam int PT_OE   = 2;

  typedef enum logic [1:0] {
    XB_ZERO     = 2'd0,
    XB_ONE      = 2'd1,
    XB_TERM     = 2'd2,
    XB_FEEDBACK = 2'd3
  } xor_mode_e;

  typedef enum logic [1:0] {
    OE_OFF     = 2'd0,
    OE_ON      = 2'd1,
    OE_TERM    = 2'd2,
    OE_OFF_ALT = 2'd3
  } oe_mode_e;
endpackage

// File: rtl/pld_pt_array.sv
module pld_pt_array #(
  parameter int IN_W = 16,
  parameter int N_PT = 5
) (
  input  logic [IN_W-1:0]      lit_i,
  input  logic [N_PT*IN_W-1:0] true_en_i,
  input  logic [N_PT*IN_W-1:0] comp_en_i,
  output logic [N_PT-1:0]      pt_o
);
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [IN_W-1:0] t_en, c_en;
    assign t_en = true_en_i[t*IN_W +: IN_W];
    assign c_en = comp_en_i[t*IN_W +: IN_W];
    // each literal passes unless enabled and failing its polarity
    assign pt_o[t] = &((~t_en | lit_i) & (~c_en | ~lit_i));
  end
endmodule

// File: rtl/pld_pt_steer.sv
module pld_pt_steer
  import pld_mc_pkg::*;
(
  input  logic [N_PT-1:0]    pt_i,
  input  logic [N_STEER-1:0] route_i,
  input  logic               cascade_i,
  output logic               sum_o,
  output logic               xor_pt_o,
  output logic               ffd_pt_o,
  output logic               oe_pt_o
);
  logic [N_PT-1:0] to_sum;

  for (genvar t = 0; t < N_PT; t++) begin : g_route
    if (t < N_STEER) begin : g_steerable
      assign to_sum[t] = pt_i[t] & ~route_i[t];
    end else begin : g_fixed
      assign to_sum[t] = pt_i[t];
    end
  end

  assign sum_o    = (|to_sum) | cascade_i;
  assign xor_pt_o = pt_i[PT_XOR] & route_i[PT_XOR];
  assign ffd_pt_o = pt_i[PT_FFD] & route_i[PT_FFD];
  assign oe_pt_o  = pt_i[PT_OE]  & route_i[PT_OE];
endmodule

// File: rtl/pld_mc_core.sv
module pld_mc_core
  import pld_mc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      sum_i,
  input  logic      xor_pt_i,
  input  logic      ffd_pt_i,
  input  logic      oe_pt_i,
  input  xor_mode_e xor_mode_i,
  input  logic      d_sel_i,
  input  logic      out_sel_i,
  input  logic      fb_sel_i,
  input  oe_mode_e  oe_mode_i,
  output logic      pin_o,
  output logic      oe_o,
  output logic      fb_o
);
  logic q, xor_b, xor_out, d;

  always_comb begin
    unique case (xor_mode_i)
      XB_ZERO:     xor_b = 1'b0;
      XB_ONE:      xor_b = 1'b1;
      XB_TERM:     xor_b = xor_pt_i;
      XB_FEEDBACK: xor_b = q;
      default:     xor_b = 1'b0;
    endcase
  end

  assign xor_out = sum_i ^ xor_b;
  assign d       = d_sel_i ? ffd_pt_i : xor_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else            q <= d;
  end

  assign pin_o = out_sel_i ? q : xor_out;
  assign fb_o  = fb_sel_i  ? q : xor_out;

  always_comb begin
    unique case (oe_mode_i)
      OE_ON:   oe_o = 1'b1;
      OE_TERM: oe_o = oe_pt_i;
      default: oe_o = 1'b0;
    endcase
  end

  assert_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q == 1'b0));

  assert_term_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && d_sel_i) |=> (q == $past(ffd_pt_i)));

  assert_toggle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !d_sel_i && xor_mode_i == XB_FEEDBACK && sum_i) |=> (q != $past(q)));
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int GLB_W = 8,
  parameter int RGN_W = 8,
  localparam int IN_W = GLB_W + RGN_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic [GLB_W-1:0]     glb_i,
  input  logic [RGN_W-1:0]     rgn_i,
  input  logic                 cascade_i,
  input  logic [N_PT*IN_W-1:0] true_en_i,
  input  logic [N_PT*IN_W-1:0] comp_en_i,
  input  logic [N_STEER-1:0]   route_i,
  input  logic [1:0]           xor_mode_i,
  input  logic                 d_sel_i,
  input  logic                 out_sel_i,
  input  logic                 fb_sel_i,
  input  logic [1:0]           oe_mode_i,
  output logic                 pin_o,
  output logic                 pin_oe_o,
  output logic                 fb_o,
  output logic                 cascade_o
);
  logic [IN_W-1:0] lit;
  logic [N_PT-1:0] pt;
  logic sum, xor_pt, ffd_pt, oe_pt;

  assign lit = {rgn_i, glb_i};

  pld_pt_array #(.IN_W(IN_W), .N_PT(N_PT)) u_array (
    .lit_i     (lit),
    .true_en_i (true_en_i),
    .comp_en_i (comp_en_i),
    .pt_o      (pt)
  );

  pld_pt_steer u_steer (
    .pt_i      (pt),
    .route_i   (route_i),
    .cascade_i (cascade_i),
    .sum_o     (sum),
    .xor_pt_o  (xor_pt),
    .ffd_pt_o  (ffd_pt),
    .oe_pt_o   (oe_pt)
  );

  assign cascade_o = sum;

  pld_mc_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .sum_i      (sum),
    .xor_pt_i   (xor_pt),
    .ffd_pt_i   (ffd_pt),
    .oe_pt_i    (oe_pt),
    .xor_mode_i (xor_mode_e'(xor_mode_i)),
    .d_sel_i    (d_sel_i),
    .out_sel_i  (out_sel_i),
    .fb_sel_i   (fb_sel_i),
    .oe_mode_i  (oe_mode_e'(oe_mode_i)),
    .pin_o      (pin_o),
    .oe_o       (pin_oe_o),
    .fb_o       (fb_o)
  );

  assert_cascade_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_i |-> cascade_o);

  assert_oe_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_mode_i == 2'd0 || oe_mode_i == 2'd3) |-> !pin_oe_o);

  assert_oe_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_mode_i == 2'd1) |-> pin_oe_o);

  assert_same_select_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel_i == fb_sel_i) |-> (pin_o == fb_o));
endmodule

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;
  localparam int GLB_W = 4;
  localparam int RGN_W = 4;
  localparam int IN_W  = GLB_W + RGN_W;
  localparam int NP    = 5;
  localparam int TW    = NP * IN_W;
  localparam int NCH   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, clr = 1'b0, cas = 1'b0;
  logic [GLB_W-1:0] glb = '0;
  logic [RGN_W-1:0] rgn = '0;
  logic [TW-1:0] te = '0, ce = '0;
  logic [2:0] route = '0;
  logic [1:0] xmode = '0, oem = '0;
  logic dsel = 1'b0, osel = 1'b0, fsel = 1'b0;
  logic pin, oe, fb, cas_o;

  pld_macrocell #(.GLB_W(GLB_W), .RGN_W(RGN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .glb_i(glb), .rgn_i(rgn),
    .cascade_i(cas), .true_en_i(te), .comp_en_i(ce), .route_i(route),
    .xor_mode_i(xmode), .d_sel_i(dsel), .out_sel_i(osel), .fb_sel_i(fsel),
    .oe_mode_i(oem), .pin_o(pin), .pin_oe_o(oe), .fb_o(fb), .cascade_o(cas_o)
  );

  // eight-cell cascade chain
  logic [TW-1:0] ch_te [NCH];
  logic [TW-1:0] ch_ce [NCH];
  logic [NCH-1:0] ch_cas;
  for (genvar k = 0; k < NCH; k++) begin : g_chain
    logic c_in, p_o, e_o, f_o;
    if (k == 0) begin : g_first
      assign c_in = 1'b0;
    end else begin : g_next
      assign c_in = ch_cas[k-1];
    end
    pld_macrocell #(.GLB_W(GLB_W), .RGN_W(RGN_W)) u_ch (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(1'b0), .glb_i(glb), .rgn_i(rgn),
      .cascade_i(c_in), .true_en_i(ch_te[k]), .comp_en_i(ch_ce[k]),
      .route_i(3'b000), .xor_mode_i(2'd0), .d_sel_i(1'b0), .out_sel_i(1'b0),
      .fb_sel_i(1'b0), .oe_mode_i(2'd1), .pin_o(p_o), .pin_oe_o(e_o),
      .fb_o(f_o), .cascade_o(ch_cas[k])
    );
  end

  typedef struct {
    string    tag;
    bit       chain;
    logic     pin, oe, fb, cas;
    logic [NCH-1:0] chv;
  } item_t;

  item_t sb_q[$];
  event  item_ev;
  int n_chk = 0, n_fail = 0;
  logic mq = 1'b0;

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor
  initial forever begin
    @(item_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.chain) begin
        n_chk++;
        if (ch_cas !== it.chv) begin
          n_fail++;
          $display("FAIL %s chain cascade: actual %b expected %b", it.tag, ch_cas, it.chv);
        end
      end else begin
        check1(it.tag, "pin_o", pin, it.pin);
        check1(it.tag, "pin_oe_o", oe, it.oe);
        check1(it.tag, "fb_o", fb, it.fb);
        check1(it.tag, "cascade_o", cas_o, it.cas);
      end
    end
  end

  // behavioural model of one cell
  function automatic void model(input logic q, output logic p, output logic e,
                                output logic f, output logic c, output logic d);
    logic [IN_W-1:0] lit;
    logic [NP-1:0] pt;
    logic sum, x;
    lit = {rgn, glb};
    for (int t = 0; t < NP; t++) begin
      pt[t] = 1'b1;
      for (int k = 0; k < IN_W; k++) begin
        if (te[t*IN_W+k] && !lit[k]) pt[t] = 1'b0;
        if (ce[t*IN_W+k] &&  lit[k]) pt[t] = 1'b0;
      end
    end
    sum = cas;
    for (int t = 0; t < NP; t++)
      if (!(t < 3 && route[t])) sum = sum | pt[t];
    case (xmode)
      2'd0: x = sum;
      2'd1: x = ~sum;
      2'd2: x = sum ^ (route[0] & pt[0]);
      default: x = sum ^ q;
    endcase
    d = dsel ? (route[1] & pt[1]) : x;
    p = osel ? q : x;
    f = fsel ? q : x;
    e = (oem == 2'd1) ? 1'b1 : (oem == 2'd2) ? (route[2] & pt[2]) : 1'b0;
    c = sum;
  endfunction

  // driver: one clock of stimulus with expected values pushed to the scoreboard
  task automatic step(input string tag);
    item_t it;
    logic d;
    @(negedge clk);
    #1;
    model(mq, it.pin, it.oe, it.fb, it.cas, d);
    it.tag = tag; it.chain = 1'b0; it.chv = '0;
    sb_q.push_back(it);
    -> item_ev;
    @(posedge clk);
    if (rst_n) mq = clr ? 1'b0 : d;
    #1;
  endtask

  task automatic rand_lits();
    glb = GLB_W'($urandom);
    rgn = RGN_W'($urandom);
    cas = ($urandom % 6) == 0;
  endtask

  task automatic rand_cfg();
    for (int t = 0; t < NP; t++) begin
      te[t*IN_W +: IN_W] = IN_W'($urandom & $urandom & $urandom);
      ce[t*IN_W +: IN_W] = IN_W'($urandom & $urandom & $urandom);
    end
    route = 3'($urandom);
    xmode = 2'($urandom);
    oem   = 2'($urandom);
    dsel  = 1'($urandom);
    osel  = 1'($urandom);
    fsel  = 1'($urandom);
  endtask

  // term t forced to 0 (contradictory literal) or 1 (empty)
  function automatic void set_term(input int t, input bit one);
    te[t*IN_W +: IN_W] = one ? '0 : IN_W'(1);
    ce[t*IN_W +: IN_W] = one ? '0 : IN_W'(1);
  endfunction

  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin ch_te[k] = '0; ch_ce[k] = '0; end
    // R9: reset state seen through registered pin and feedback
    osel = 1'b1; fsel = 1'b1; oem = 2'd0;
    for (int t = 0; t < NP; t++) set_term(t, 1'b1);
    step("R9 reset");
    rst_n = 1'b1;

    // R1: empty terms are 1, contradictory terms are 0
    osel = 1'b0; fsel = 1'b0;
    step("R1 empty terms");
    for (int t = 0; t < NP; t++) set_term(t, 1'b0);
    step("R1 zero terms");
    set_term(4, 1'b1);
    step("R1 R3 single term");

    // R2: routed terms leave the sum
    for (int t = 0; t < NP; t++) set_term(t, t < 3);
    route = 3'b111;
    step("R2 all steered");
    route = 3'b010;
    step("R2 partial steer");

    // R5: polarity and term operand
    route = 3'b001; set_term(0, 1'b1); set_term(1, 1'b0); set_term(2, 1'b0);
    xmode = 2'd1; step("R5 invert");
    xmode = 2'd2; step("R5 term operand");
    route = 3'b000; step("R5 unrouted operand");

    // R5: toggle register
    for (int t = 0; t < NP; t++) set_term(t, t == 3);
    xmode = 2'd3; osel = 1'b1; fsel = 1'b0;
    repeat (4) step("R5 toggle");
    set_term(3, 1'b0);
    repeat (2) step("R5 hold");

    // R6 R7: buried register, pin combinational, feedback registered
    xmode = 2'd0; dsel = 1'b1; route = 3'b010; osel = 1'b0; fsel = 1'b1;
    te = '0; ce = '0;
    te[1*IN_W +: IN_W] = IN_W'(2);
    for (int t = 0; t < NP; t++) if (t != 1) set_term(t, 1'b0);
    for (int i = 0; i < 8; i++) begin
      glb = GLB_W'(i);
      step("R6 R7 buried register");
    end
    route = 3'b000; glb = '1;
    step("R6 unrouted data");
    step("R6 unrouted data");

    // R9: synchronous clear wins over data
    route = 3'b010; clr = 1'b1;
    step("R9 clear");
    step("R9 clear");
    clr = 1'b0;
    step("R9 after clear");

    // R8: enable modes, pin value unaffected
    route = 3'b100; set_term(2, 1'b1); dsel = 1'b0;
    for (int m = 0; m < 4; m++) begin
      oem = 2'(m);
      step("R8 oe mode");
    end
    route = 3'b000; oem = 2'd2;
    step("R8 unrouted enable");

    // R3: cascade input
    for (int t = 0; t < NP; t++) set_term(t, 1'b0);
    cas = 1'b1; step("R3 cascade in");
    cas = 1'b0; step("R3 cascade low");

    // random configurations, static for 20 cycles each
    for (int c = 0; c < 100; c++) begin
      rand_cfg();
      clr = 1'b0;
      for (int v = 0; v < 20; v++) begin
        rand_lits();
        clr = ($urandom % 16) == 0;
        step("R1 R2 R3 R5 R6 R7 R8 R9 random");
      end
    end
    clr = 1'b0;

    // R9: asynchronous reset mid-run
    osel = 1'b1; fsel = 1'b1;
    @(negedge clk);
    rst_n = 1'b0; mq = 1'b0;
    step("R9 async reset");
    rst_n = 1'b1;

    // R4: one true term walked across the 40-term chain
    for (int j = -1; j < NCH * NP; j++) begin
      item_t it;
      @(negedge clk);
      for (int k = 0; k < NCH; k++)
        for (int t = 0; t < NP; t++) begin
          bit one;
          one = (k * NP + t) == j;
          ch_te[k][t*IN_W +: IN_W] = one ? '0 : IN_W'(1);
          ch_ce[k][t*IN_W +: IN_W] = one ? '0 : IN_W'(1);
        end
      #1;
      it.tag = "R4 chain"; it.chain = 1'b1;
      it.pin = 1'b0; it.oe = 1'b0; it.fb = 1'b0; it.cas = 1'b0;
      for (int k = 0; k < NCH; k++) it.chv[k] = (j >= 0) && (k >= j / NP);
      sb_q.push_back(it);
      -> item_ev;
    end

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule